// File: doc/BRIEF.md
# Parameter Selection Exchange Monitor

This block watches a smart-card line passively, after the answer-to-reset, for the optional exchange that negotiates the transmission rate. A byte receiver upstream hands it each received character with a one-cycle valid strobe. A command-level tracker says when the line is between commands. A waiting-time counter raises a timeout when the line has been quiet for too long. The reader's request and the card's reply arrive on the same stream, one after the other. The block never drives the line and never looks inside command data.

The exchange is recognised when the block is idle, the line is between commands, and a start byte (0xFF by default) arrives. The block then walks through the request frame, with fields PTSS, PTS0, optional PTS1/PTS2/PTS3, and PCK. It then walks through a response frame laid out the same way. In each frame, that frame's own PTS0 decides which optional fields are present. Every frame is checked with an XOR over its bytes. When the response ends cleanly, the block pulses apply-rate so that a separate timing block can reprogram the rate divisor from the Fi/Di nibbles.

The controller has three phases. Inside a frame it keeps a current field.
- **PH_IDLE**: waiting between commands.
- **PH_REQ**: inside the request frame.
- **PH_RSP**: inside the response frame.

The field is one of FLD_PTSS, FLD_PTS0, FLD_PTS1, FLD_PTS2, FLD_PTS3 and FLD_PCK. The transitions are:
- **Start**: PH_IDLE to PH_REQ/FLD_PTS0, on the start byte.
- **Field advance**: within a phase, as each byte arrives.
- **Turnaround**: PH_REQ/FLD_PCK to PH_RSP/FLD_PTSS.
- **Completion**: PH_RSP/FLD_PCK to PH_IDLE.
- **Abort**: any non-idle phase to PH_IDLE, on timeout.

Top module: `pss_sniffer`

## Requirements
- R1: After reset `busy_o`, `apply_rate_o`, `done_o`, `abort_o` and `err_o` are 0, `fi_o` and `di_o` equal DEF_FI and DEF_DI (both 1), and both frame outputs are all zero.
- R2: An exchange starts only when the block is idle, `idle_i` is high and a valid byte equal to START_CODE (0xFF) arrives; `busy_o` is high from the next cycle. Any other byte, or the start byte while `idle_i` is low, leaves `busy_o` low.
- R3: Each frame is PTSS, PTS0, then PTS1 if PTS0 bit 4 is set, PTS2 if bit 5 is set, PTS3 if bit 6 is set, then PCK. Absent fields are skipped. Bytes are stored by slot: PTSS=0, PTS0=1, PTS1=2, PTS2=3, PTS3=4, PCK=5, with slot k at bits 8k+7:8k of the frame output. Absent slots read zero.
- R4: After the request PCK, the next byte is the response PTSS. The response is decoded by the same rules using its own PTS0, independently of the request's PTS0.
- R5: A response PTS1 byte sets `fi_o` to its upper nibble and `di_o` to its lower nibble.
- R6: In the cycle after a response PCK whose exchange passed all checks, `apply_rate_o` and `done_o` are high for exactly one cycle, with the negotiated `fi_o`/`di_o`. The block then returns to idle.
- R7: If the response carries no PTS1, `apply_rate_o` is still pulsed, with `fi_o`=1 and `di_o`=1.
- R8: A frame passes its check when the XOR of all its bytes, PCK included, is zero. A failure in either frame sets `err_o`. `err_o` suppresses `apply_rate_o` while `done_o` still pulses, and it is cleared when the next exchange starts.
- R9: A timeout while busy pulses `abort_o` for one cycle and returns to idle without `done_o`. A timeout while idle has no effect.
- R10: Both stored frames hold their contents after completion until the next exchange starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| idle_i | input | 1 | Line is between commands |
| timeout_i | input | 1 | Waiting time expired |
| busy_o | output | 1 | Exchange in progress |
| fi_o | output | 4 | Negotiated Fi nibble |
| di_o | output | 4 | Negotiated Di nibble |
| apply_rate_o | output | 1 | One-cycle pulse: reprogram rate |
| done_o | output | 1 | One-cycle pulse: exchange completed |
| abort_o | output | 1 | One-cycle pulse: exchange abandoned |
| err_o | output | 1 | Frame check failed in last exchange |
| req_frame_o | output | 48 | Stored request bytes, six slots |
| rsp_frame_o | output | 48 | Stored response bytes, six slots |

## Verification
The bench builds the block with its default parameters: START_CODE 0xFF and a default rate of Fi=1, Di=1.

These defaults let directed frames exercise several cases:
- A response that carries PTS1 with values other than 1/1 is distinguishable from the default-rate path.
- Frames whose PTS0 selects every optional field, none of them, or non-adjacent ones reach every field transition.
- Request and response frames that select different optional fields show that each frame's layout comes from its own PTS0.

Deliberately corrupted PCK bytes reach the error path. Timeouts placed mid-frame and while idle reach both abort branches.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int BYTE_W = 8;
    localparam int SLOTS  = 6;
    localparam int SLOT_W = 3;
    localparam int FRAME_W = SLOTS * BYTE_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_RSP  = 2'd2
    } phase_e;

    typedef enum logic [SLOT_W-1:0] {
        FLD_PTSS = 3'd0,
        FLD_PTS0 = 3'd1,
        FLD_PTS1 = 3'd2,
        FLD_PTS2 = 3'd3,
        FLD_PTS3 = 3'd4,
        FLD_PCK  = 3'd5
    } field_e;
endpackage

// File: rtl/pss_field_next.sv
module pss_field_next
    import pss_pkg::*;
(
    input  field_e     cur_i,
    input  logic [2:0] sel_i,   // PTS0 bits 6:4 of the frame
    output field_e     nxt_i
);
    always_comb begin
        nxt_i = FLD_PTSS;
        unique case (cur_i)
            FLD_PTSS: nxt_i = FLD_PTS0;
            FLD_PTS0: begin
                if (sel_i[0])      nxt_i = FLD_PTS1;
                else if (sel_i[1]) nxt_i = FLD_PTS2;
                else if (sel_i[2]) nxt_i = FLD_PTS3;
                else               nxt_i = FLD_PCK;
            end
            FLD_PTS1: begin
                if (sel_i[1])      nxt_i = FLD_PTS2;
                else if (sel_i[2]) nxt_i = FLD_PTS3;
                else               nxt_i = FLD_PCK;
            end
            FLD_PTS2: nxt_i = sel_i[2] ? FLD_PTS3 : FLD_PCK;
            FLD_PTS3: nxt_i = FLD_PCK;
            FLD_PCK:  nxt_i = FLD_PTSS;
            default:  nxt_i = FLD_PTSS;
        endcase
    end
endmodule

// File: rtl/pss_frame_store.sv
module pss_frame_store
    import pss_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               wr_i,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic [BYTE_W-1:0]  data_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               chk_ok_o
);
    logic [BYTE_W-1:0] acc_q;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_i && slot_i == SLOT_W'(k))
                byte_q <= data_i;
            else if (clear_i)
                byte_q <= '0;
        end
        assign frame_o[k*BYTE_W +: BYTE_W] = byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear_i && wr_i)
            acc_q <= data_i;
        else if (clear_i)
            acc_q <= '0;
        else if (wr_i)
            acc_q <= acc_q ^ data_i;
    end

    assign chk_ok_o = ((acc_q ^ data_i) == '0);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (slot_i < SLOT_W'(SLOTS)));  // R3
endmodule

// File: rtl/pss_sniffer.sv
module pss_sniffer
    import pss_pkg::*;
#(
    parameter logic [7:0] START_CODE = 8'hFF,
    parameter logic [3:0] DEF_FI     = 4'd1,
    parameter logic [3:0] DEF_DI     = 4'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_byte_i,
    input  logic        idle_i,
    input  logic        timeout_i,
    output logic        busy_o,
    output logic [3:0]  fi_o,
    output logic [3:0]  di_o,
    output logic        apply_rate_o,
    output logic        done_o,
    output logic        abort_o,
    output logic        err_o,
    output logic [47:0] req_frame_o,
    output logic [47:0] rsp_frame_o
);
    phase_e phase_q, phase_d;
    field_e field_q, field_d, field_nxt;
    logic [2:0] sel_q, sel_now;
    logic start, abort_ev, take, at_pck;
    logic req_wr, req_clr, rsp_wr, rsp_clr, req_ok, rsp_ok;
    logic [SLOT_W-1:0] req_slot;

    assign start    = (phase_q == PH_IDLE) && rx_valid_i && idle_i && (rx_byte_i == START_CODE);
    assign abort_ev = (phase_q != PH_IDLE) && timeout_i;
    assign take     = (phase_q != PH_IDLE) && rx_valid_i && !timeout_i;
    assign at_pck   = take && (field_q == FLD_PCK);
    assign sel_now  = (field_q == FLD_PTS0) ? rx_byte_i[6:4] : sel_q;

    pss_field_next u_next (
        .cur_i (field_q),
        .sel_i (sel_now),
        .nxt_i (field_nxt)
    );

    // Frame storage, one per direction
    assign req_wr   = start || (take && phase_q == PH_REQ);
    assign req_clr  = start;
    assign req_slot = start ? SLOT_W'(FLD_PTSS) : SLOT_W'(field_q);
    assign rsp_wr   = take && (phase_q == PH_RSP);
    assign rsp_clr  = start || (rsp_wr && field_q == FLD_PTSS);

    pss_frame_store u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (req_clr),
        .wr_i     (req_wr),
        .slot_i   (req_slot),
        .data_i   (rx_byte_i),
        .frame_o  (req_frame_o),
        .chk_ok_o (req_ok)
    );

    pss_frame_store u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (rsp_clr),
        .wr_i     (rsp_wr),
        .slot_i   (SLOT_W'(field_q)),
        .data_i   (rx_byte_i),
        .frame_o  (rsp_frame_o),
        .chk_ok_o (rsp_ok)
    );

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        field_d = field_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_REQ;
                    field_d = FLD_PTS0;
                end
            end
            PH_REQ: begin
                if (abort_ev) begin
                    phase_d = PH_IDLE;
                    field_d = FLD_PTSS;
                end else if (take) begin
                    if (field_q == FLD_PCK) begin
                        phase_d = PH_RSP;
                        field_d = FLD_PTSS;
                    end else begin
                        field_d = field_nxt;
                    end
                end
            end
            PH_RSP: begin
                if (abort_ev) begin
                    phase_d = PH_IDLE;
                    field_d = FLD_PTSS;
                end else if (take) begin
                    if (field_q == FLD_PCK) begin
                        phase_d = PH_IDLE;
                        field_d = FLD_PTSS;
                    end else begin
                        field_d = field_nxt;
                    end
                end
            end
            default: begin
                phase_d = PH_IDLE;
                field_d = FLD_PTSS;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            field_q <= FLD_PTSS;
        end else begin
            phase_q <= phase_d;
            field_q <= field_d;
        end
    end

    // Outputs and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q        <= '0;
            err_o        <= 1'b0;
            apply_rate_o <= 1'b0;
            done_o       <= 1'b0;
            abort_o      <= 1'b0;
            fi_o         <= DEF_FI;
            di_o         <= DEF_DI;
        end else begin
            apply_rate_o <= 1'b0;
            done_o       <= 1'b0;
            abort_o      <= abort_ev;
            if (take && field_q == FLD_PTS0)
                sel_q <= rx_byte_i[6:4];
            if (start)
                err_o <= 1'b0;
            else if (at_pck && phase_q == PH_REQ && !req_ok)
                err_o <= 1'b1;
            else if (at_pck && phase_q == PH_RSP && !rsp_ok)
                err_o <= 1'b1;
            if (at_pck && phase_q == PH_RSP) begin
                done_o       <= 1'b1;
                apply_rate_o <= !err_o && rsp_ok;
            end
            if (rsp_wr && field_q == FLD_PTSS) begin
                fi_o <= DEF_FI;
                di_o <= DEF_DI;
            end else if (rsp_wr && field_q == FLD_PTS1) begin
                fi_o <= rx_byte_i[7:4];
                di_o <= rx_byte_i[3:0];
            end
        end
    end

    assign busy_o = (phase_q != PH_IDLE);

    AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(rx_valid_i && idle_i && rx_byte_i == START_CODE));  // R2
    AST_APPLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        apply_rate_o |-> (done_o && !busy_o));  // R6
    AST_APPLY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        apply_rate_o |-> !err_o);  // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!busy_o && !done_o));  // R9
    AST_ABORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(busy_o));  // R9
    AST_APPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        apply_rate_o |=> !apply_rate_o);  // R6
endmodule

// File: tb/pss_sniffer_bench.sv
module pss_sniffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        idle = 1'b1;
    logic        tmo = 1'b0;
    logic        busy, apply, done, abort, err;
    logic [3:0]  fi, di;
    logic [47:0] reqf, rspf;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pss_sniffer u_pss_sniffer (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .idle_i(idle), .timeout_i(tmo), .busy_o(busy), .fi_o(fi), .di_o(di),
        .apply_rate_o(apply), .done_o(done), .abort_o(abort), .err_o(err),
        .req_frame_o(reqf), .rsp_frame_o(rspf)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_timeout();
        @(negedge clk);
        tmo = 1'b1;
        @(negedge clk);
        tmo = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 fi/di", {fi, di}, 8'h11);
        chk("R1 pulses", {apply, done, abort, err}, 0);
        chk("R1 frames", reqf | rspf, 0);
    endtask

    task automatic t_minimal();
        send(8'hFF); chk("R2 busy after start", busy, 1);
        send(8'h00); send(8'hFF);
        chk("R4 still busy after req PCK", busy, 1);
        send(8'hFF); send(8'h00); send(8'hFF);
        chk("R7 apply default", {apply, done, fi, di}, {2'b11, 8'h11});
        chk("R6 back to idle", busy, 0);
        @(negedge clk);
        chk("R6 single-cycle pulse", {apply, done}, 0);
    endtask

    task automatic t_pts1();
        send(8'hFF); send(8'h10); send(8'h95); send(8'h7A);
        send(8'hFF); send(8'h10); send(8'h95);
        chk("R5 fi/di from rsp PTS1", {fi, di}, 8'h95);
        send(8'h7A);
        chk("R6 apply with rate", {apply, done, err}, 3'b110);
        chk("R3 req frame", reqf, 48'h7A_00_00_95_10_FF);
        chk("R10 rsp frame held", rspf, 48'h7A_00_00_95_10_FF);
    endtask

    task automatic t_sparse();
        send(8'hFF); send(8'h60); send(8'hAA); send(8'hBB); send(8'h8E);
        send(8'hFF); send(8'h50); send(8'h13); send(8'h22); send(8'h9E);
        chk("R4 rsp own PTS0 apply", {apply, fi, di}, {1'b1, 8'h13});
        chk("R3 req PTS2/PTS3 slots", reqf, 48'h8E_BB_AA_00_60_FF);
        chk("R4 rsp PTS1/PTS3 slots", rspf, 48'h9E_22_00_13_50_FF);
        repeat (3) @(negedge clk);
        chk("R10 frames held", {reqf[7:0], rspf[47:40]}, 16'hFF_9E);
    endtask

    task automatic t_bad_pck();
        send(8'hFF); send(8'h00); send(8'h00);
        chk("R8 req check fail", err, 1);
        send(8'hFF); send(8'h00); send(8'hFF);
        chk("R8 apply suppressed", {apply, done, err}, 3'b011);
        send(8'hFF);
        chk("R8 err cleared at start", err, 0);
        send(8'h00); send(8'hFF);
        send(8'hFF); send(8'h10); send(8'h95); send(8'h00);
        chk("R8 rsp check fail", {apply, done, err}, 3'b011);
    endtask

    task automatic t_timeout();
        pulse_timeout();
        chk("R9 idle timeout ignored", {abort, busy}, 0);
        send(8'hFF); send(8'h10);
        pulse_timeout();
        chk("R9 abort", {abort, busy, done}, 3'b100);
        send(8'h95);
        chk("R2 non-start byte ignored", busy, 0);
        idle = 1'b0;
        send(8'hFF);
        chk("R2 not between commands", busy, 0);
        idle = 1'b1;
        send(8'hFF); send(8'h20); send(8'h33); send(8'hEC);
        send(8'hFF); send(8'h00); send(8'hFF);
        chk("R9 fresh exchange after abort", {apply, fi, di}, {1'b1, 8'h11});
        chk("R3 PTS2 only", reqf, 48'hEC_00_33_00_20_FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_minimal();
        t_pts1();
        t_sparse();
        t_bad_pck();
        t_timeout();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule